// File: doc/BRIEF.md
# Serial Configuration Port with Staged Commit

This block receives 32-bit configuration words over a three-wire serial link made of a serial clock, a data line and a load-enable line. Every rising edge of the serial clock shifts one data bit into a 32-bit shift register, most significant bit first. A rising edge on load-enable hands the word to one of five latches. The three lowest bits of the word select the latch; the remaining bits carry the fields.

The three serial pins are sampled by the chip's core clock, and edges are found by comparing each sample with the previous one. So each high and low phase of the serial clock and of load-enable must last at least two core cycles. The decoded fields are presented as plain outputs for the rest of the synthesizer to use.

Several fields are staged and do not take effect when they are written. These are the lower thirteen fraction bits, the current setting, the reference doubler and the reference count. Writing the integer/fraction latch (code 000) commits all of them at once. That same write also emits a one-cycle commit strobe, which the modulator uses as its reset request.

Top module: `serial_cfg_port`

## Requirements
- R1: On each rising edge of `ser_clk`, the bit on `ser_data` is shifted into the low end of a 32-bit shift register, so the word arrives most significant bit first. Only the last 32 bits shifted before a load are used.
- R2: On a rising edge of `ser_load`, word bits [2:0] pick the destination: 000 is the integer/fraction latch, 001 the fine-fraction latch, 010 the reference latch, 011 the function latch and 100 the test latch. The outputs change two core cycles after `ser_load` is first seen high.
- R3: A code-000 load takes effect at once for `mux_sel_o` (word bits [30:27]), `int_o` (bits [26:15]) and `frac_o[24:13]` (bits [14:12] and down to [3], that is bits [14:3]).
- R4: A code-001 load places word bits [27:15] in a staging register without changing `frac_o`. The next code-000 load copies them to `frac_o[12:0]`.
- R5: A code-010 load takes effect at once for `slip_en_o` (bit [28]), `presc_o` (bit [22]) and `refhalf_o` (bit [21]).
- R6: A code-010 load stages `icp_o` (bits [27:24]), `dbl_o` (bit [20]) and `rcnt_o` (bits [19:15]). These outputs change only on the next code-000 load.
- R7: A code-011 load takes effect at once for the following outputs: `modrst_dis_o` (bit [14]), `lock_prec_o` (bit [7]), `pol_o` (bit [6]), `pd_o` (bit [5]), `cp_hiz_o` (bit [4]) and `cnt_rst_o` (bit [3]).
- R8: A code-100 load copies word bits [31:3] to `test_o` at once.
- R9: Loads with codes 101, 110 and 111 change no output and produce no commit strobe.
- R10: `commit_o` is high for exactly one core cycle per code-000 load, in the cycle in which the committed values first appear. It is low at all other times.
- R11: While `pd_o` is 1, loads are still accepted and committed, and all stored values are kept.
- R12: An asynchronous active-low reset `rst_n` clears every output and every staging register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_load | input | 1 | Load enable; a rising edge commits the word |
| mux_sel_o | output | 4 | Output multiplexer select |
| int_o | output | 12 | Integer divide value |
| frac_o | output | 25 | Active fraction value |
| slip_en_o | output | 1 | Cycle-slip reduction enable |
| icp_o | output | 4 | Active charge-pump current setting |
| presc_o | output | 1 | Prescaler select |
| refhalf_o | output | 1 | Reference divide-by-2 enable |
| dbl_o | output | 1 | Active reference doubler enable |
| rcnt_o | output | 5 | Active reference count |
| modrst_dis_o | output | 1 | Disable of the modulator reset on commit |
| lock_prec_o | output | 1 | Lock-detect precision |
| pol_o | output | 1 | Phase detector polarity |
| pd_o | output | 1 | Power-down |
| cp_hiz_o | output | 1 | Charge-pump high-impedance |
| cnt_rst_o | output | 1 | Counter reset |
| test_o | output | 29 | Test latch contents |
| commit_o | output | 1 | One-cycle strobe on every code-000 load |

## Verification
The bench targets the staged fields first. It writes the fine-fraction and reference latches, then checks that the active fraction, current, doubler and count hold still until a code-000 load. A design that forwarded them early would change the synthesizer frequency in two steps. It also sends the undefined codes with busy payloads, which a loose decoder would let corrupt the test or function latch. Further cases are a word preceded by eight extra bits, to catch wrong shift direction or length, and loads while powered down, to catch a design that freezes its registers in that state. A reference model in the bench is compared with every output on every core cycle, so a strobe that is late, doubled or missing is also caught.

// File: rtl/serial_cfg_port.sv
module serial_cfg_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_clk,
  input  logic        ser_data,
  input  logic        ser_load,
  output logic [3:0]  mux_sel_o,
  output logic [11:0] int_o,
  output logic [24:0] frac_o,
  output logic        slip_en_o,
  output logic [3:0]  icp_o,
  output logic        presc_o,
  output logic        refhalf_o,
  output logic        dbl_o,
  output logic [4:0]  rcnt_o,
  output logic        modrst_dis_o,
  output logic        lock_prec_o,
  output logic        pol_o,
  output logic        pd_o,
  output logic        cp_hiz_o,
  output logic        cnt_rst_o,
  output logic [28:0] test_o,
  output logic        commit_o
);

  localparam int WORD_W = 32;
  localparam int CODE_W = 3;

  logic              sclk_q, sclk_d, sdat_q, ld_q, ld_d;
  logic [WORD_W-1:0] shift_q;
  logic [12:0]       flo_stg;
  logic [3:0]        icp_stg;
  logic              dbl_stg;
  logic [4:0]        rcnt_stg;

  wire sclk_rise = sclk_q & ~sclk_d;
  wire ld_rise   = ld_q & ~ld_d;
  wire [CODE_W-1:0] code = shift_q[CODE_W-1:0];
  wire wr0 = ld_rise && code == 3'd0;
  wire wr1 = ld_rise && code == 3'd1;
  wire wr2 = ld_rise && code == 3'd2;
  wire wr3 = ld_rise && code == 3'd3;
  wire wr4 = ld_rise && code == 3'd4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sclk_d <= 1'b0;
      sdat_q <= 1'b0;
      ld_q   <= 1'b0;
      ld_d   <= 1'b0;
    end else begin
      sclk_q <= ser_clk;
      sclk_d <= sclk_q;
      sdat_q <= ser_data;
      ld_q   <= ser_load;
      ld_d   <= ld_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else if (sclk_rise) shift_q <= {shift_q[WORD_W-2:0], sdat_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flo_stg  <= '0;
      icp_stg  <= '0;
      dbl_stg  <= 1'b0;
      rcnt_stg <= '0;
    end else begin
      if (wr1) flo_stg <= shift_q[27:15];
      if (wr2) begin
        icp_stg  <= shift_q[27:24];
        dbl_stg  <= shift_q[20];
        rcnt_stg <= shift_q[19:15];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_sel_o <= '0;
      int_o     <= '0;
      frac_o    <= '0;
      icp_o     <= '0;
      dbl_o     <= 1'b0;
      rcnt_o    <= '0;
      commit_o  <= 1'b0;
    end else begin
      commit_o <= wr0;
      if (wr0) begin
        mux_sel_o <= shift_q[30:27];
        int_o     <= shift_q[26:15];
        frac_o    <= {shift_q[14:3], flo_stg};
        icp_o     <= icp_stg;
        dbl_o     <= dbl_stg;
        rcnt_o    <= rcnt_stg;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slip_en_o <= 1'b0;
      presc_o   <= 1'b0;
      refhalf_o <= 1'b0;
    end else if (wr2) begin
      slip_en_o <= shift_q[28];
      presc_o   <= shift_q[22];
      refhalf_o <= shift_q[21];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modrst_dis_o <= 1'b0;
      lock_prec_o  <= 1'b0;
      pol_o        <= 1'b0;
      pd_o         <= 1'b0;
      cp_hiz_o     <= 1'b0;
      cnt_rst_o    <= 1'b0;
    end else if (wr3) begin
      modrst_dis_o <= shift_q[14];
      lock_prec_o  <= shift_q[7];
      pol_o        <= shift_q[6];
      pd_o         <= shift_q[5];
      cp_hiz_o     <= shift_q[4];
      cnt_rst_o    <= shift_q[3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) test_o <= '0;
    else if (wr4) test_o <= shift_q[WORD_W-1:CODE_W];
  end

  wire [89:0] all_out = {mux_sel_o, int_o, frac_o, slip_en_o, icp_o, presc_o, refhalf_o,
                         dbl_o, rcnt_o, modrst_dis_o, lock_prec_o, pol_o, pd_o, cp_hiz_o,
                         cnt_rst_o, test_o, commit_o};

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !commit_o); // R10

  AST_STAGED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_o |-> $stable({frac_o, icp_o, dbl_o, rcnt_o})); // R6

  AST_IGNORED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_rise && code > 3'd4) |=> ($stable(all_out[89:1]) && !commit_o)); // R9

  AST_PD_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_rise && pd_o && code == 3'd0) |=> commit_o); // R11

endmodule

// File: tb/serial_cfg_port_test.sv
module serial_cfg_port_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;

  logic [3:0]  mux_sel_o;
  logic [11:0] int_o;
  logic [24:0] frac_o;
  logic        slip_en_o;
  logic [3:0]  icp_o;
  logic        presc_o, refhalf_o, dbl_o;
  logic [4:0]  rcnt_o;
  logic        modrst_dis_o, lock_prec_o, pol_o, pd_o, cp_hiz_o, cnt_rst_o;
  logic [28:0] test_o;
  logic        commit_o;

  serial_cfg_port uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
    .mux_sel_o(mux_sel_o), .int_o(int_o), .frac_o(frac_o), .slip_en_o(slip_en_o),
    .icp_o(icp_o), .presc_o(presc_o), .refhalf_o(refhalf_o), .dbl_o(dbl_o),
    .rcnt_o(rcnt_o), .modrst_dis_o(modrst_dis_o), .lock_prec_o(lock_prec_o),
    .pol_o(pol_o), .pd_o(pd_o), .cp_hiz_o(cp_hiz_o), .cnt_rst_o(cnt_rst_o),
    .test_o(test_o), .commit_o(commit_o)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, strobes = 0, r0_loads = 0;
  bit done = 1'b0;
  bit live = 1'b0;
  string cur_req = "R12";

  // reference model state
  logic [31:0] m_shift;
  logic [3:0]  m_mux;  logic [11:0] m_int;  logic [24:0] m_frac;
  logic        m_slip; logic [3:0]  m_icp;  logic m_pre, m_half, m_dbl;
  logic [4:0]  m_rc;   logic [5:0]  m_f3;   logic [28:0] m_test;  logic m_str;
  logic [12:0] s_flo;  logic [3:0]  s_icp;  logic s_dbl;  logic [4:0] s_rc;

  task automatic model_reset();
    m_shift = '0; m_mux = '0; m_int = '0; m_frac = '0; m_slip = 0; m_icp = '0;
    m_pre = 0; m_half = 0; m_dbl = 0; m_rc = '0; m_f3 = '0; m_test = '0; m_str = 0;
    s_flo = '0; s_icp = '0; s_dbl = 0; s_rc = '0;
  endtask

  function automatic logic [89:0] exp_vec();
    return {m_mux, m_int, m_frac, m_slip, m_icp, m_pre, m_half, m_dbl, m_rc, m_f3, m_test, m_str};
  endfunction

  function automatic logic [89:0] dut_vec();
    return {mux_sel_o, int_o, frac_o, slip_en_o, icp_o, presc_o, refhalf_o, dbl_o, rcnt_o,
            modrst_dis_o, lock_prec_o, pol_o, pd_o, cp_hiz_o, cnt_rst_o, test_o, commit_o};
  endfunction

  task automatic chk(input string req, input logic [89:0] act, input logic [89:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // per-cycle comparison against the model, away from the edge
  always begin
    @(posedge clk);
    #3;
    if (live) chk(cur_req, dut_vec(), exp_vec());
    if (commit_o === 1'b1) strobes++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 60000", cyc);
      finish_run();
    end
  end

  task automatic send_bit(input logic b);
    @(negedge clk) begin ser_data = b; ser_clk = 1'b0; end
    @(negedge clk);
    @(negedge clk) begin ser_clk = 1'b1; m_shift = {m_shift[30:0], b}; end
    @(negedge clk);
  endtask

  task automatic model_load();
    logic [31:0] w = m_shift;
    case (w[2:0])
      3'd0: begin
        m_mux = w[30:27]; m_int = w[26:15]; m_frac = {w[14:3], s_flo};
        m_icp = s_icp; m_dbl = s_dbl; m_rc = s_rc; m_str = 1'b1; r0_loads++;
      end
      3'd1: s_flo = w[27:15];
      3'd2: begin
        m_slip = w[28]; s_icp = w[27:24]; m_pre = w[22]; m_half = w[21];
        s_dbl = w[20]; s_rc = w[19:15];
      end
      3'd3: m_f3 = {w[14], w[7], w[6], w[5], w[4], w[3]};
      3'd4: m_test = w[31:3];
      default: ;
    endcase
  endtask

  task automatic pulse_load();
    @(negedge clk) ser_clk = 1'b0;
    @(negedge clk);
    @(negedge clk) ser_load = 1'b1;
    @(negedge clk) model_load();
    @(negedge clk) begin ser_load = 1'b0; m_str = 1'b0; end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int i = 31; i >= 0; i--) send_bit(w[i]);
    pulse_load();
  endtask

  function automatic logic [31:0] r0w(input logic [3:0] mx, input logic [11:0] iv, input logic [11:0] fu);
    return {1'b0, mx, iv, fu, 3'b000};
  endfunction

  logic [89:0] snap;

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk("R12", dut_vec(), 90'd0);
    @(negedge clk) rst_n = 1'b1;
    live = 1'b1;

    // R2 R3: immediate integer/fraction latch
    cur_req = "R3";
    send_word(r0w(4'hA, 12'h12C, 12'hABC));
    chk("R3", {mux_sel_o, int_o, frac_o}, {4'hA, 12'h12C, 12'hABC, 13'h0});

    // R4: fine fraction staged
    cur_req = "R4";
    send_word({4'b0, 13'h1555, 12'h0, 3'b001});
    chk("R4", 90'(frac_o), 90'({12'hABC, 13'h0}));
    send_word(r0w(4'h3, 12'd75, 12'h001));
    chk("R4", 90'(frac_o), 90'({12'h001, 13'h1555}));

    // R5 R6: reference latch
    cur_req = "R6";
    send_word({3'b0, 1'b1, 4'h9, 1'b0, 1'b1, 1'b1, 1'b1, 5'd17, 12'h0, 3'b010});
    chk("R5", 90'({slip_en_o, presc_o, refhalf_o}), 90'(3'b111));
    chk("R6", 90'({icp_o, dbl_o, rcnt_o}), 90'd0);
    send_word(r0w(4'h5, 12'd100, 12'h800));
    chk("R6", 90'({icp_o, dbl_o, rcnt_o}), 90'({4'h9, 1'b1, 5'd17}));
    chk("R2", 90'(frac_o), 90'({12'h800, 13'h1555}));

    // R7 + R11: function latch, then loads while powered down
    cur_req = "R7";
    send_word(32'h0000_40EB);
    chk("R7", 90'({modrst_dis_o, lock_prec_o, pol_o, pd_o, cp_hiz_o, cnt_rst_o}), 90'(6'b111101));
    cur_req = "R11";
    send_word({4'b0, 13'h0AAA, 12'h0, 3'b001});
    send_word(r0w(4'hF, 12'hFFF, 12'hFFF));
    chk("R11", {int_o, frac_o, 53'(pd_o)}, {12'hFFF, 12'hFFF, 13'h0AAA, 53'd1});
    chk("R11", 90'({icp_o, dbl_o, rcnt_o}), 90'({4'h9, 1'b1, 5'd17}));

    // R8: test latch
    cur_req = "R8";
    send_word(32'hDEAD_BEEC);
    chk("R8", 90'(test_o), 90'(29'(32'hDEAD_BEEC >> 3)));

    // R9: undefined codes ignored
    cur_req = "R9";
    snap = dut_vec();
    send_word(32'hFFFF_FFFD);
    send_word(32'hFFFF_FFFE);
    send_word(32'h5555_5557);
    chk("R9", dut_vec(), snap);

    // R1: extra leading bits are pushed out
    cur_req = "R1";
    for (int k = 0; k < 8; k++) send_bit(1'b1);
    send_word(r0w(4'h6, 12'h5A5, 12'h3C3));
    chk("R1", {mux_sel_o, int_o, 74'(frac_o[24:13])}, {4'h6, 12'h5A5, 74'h3C3});

    // R10: one strobe per code-000 load
    chk("R10", 90'(strobes), 90'(r0_loads));

    // R12: asynchronous reset mid-run
    cur_req = "R12";
    @(negedge clk) begin rst_n = 1'b0; model_reset(); end
    #1 chk("R12", dut_vec(), 90'd0);
    @(negedge clk) rst_n = 1'b1;
    send_word(r0w(4'h1, 12'h020, 12'h000));
    chk("R12", 90'({icp_o, dbl_o, rcnt_o, frac_o}), 90'd0);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule